// File: doc/BRIEF.md
# Misaligned Access Splitter for a 16-bit Bus

This block sits between a processor core and a 16-bit external data bus. It takes a single access request: a byte, word or doubleword at any byte address, with 32-bit write data and a write flag. It turns that request into one, two or three bus cycles. For each cycle it drives an even byte address and two active-high lane enables. The low lane carries data bits 7:0 and the high lane carries bits 15:8.

Write bytes are routed onto the lane that matches their byte address. Read bytes captured in each cycle are placed into a 32-bit result in natural operand order: operand byte k sits at bits 8k+7:8k. Each cycle holds until `bus_ready` is sampled high. After the last cycle the block raises `done` for one clock, and `rdata` is valid at that point.

Misaligned operands use a fixed cycle order that is not ascending. The higher word is often issued first, and the sequence then wraps back to the lower address.

Top module: `bus_split_seq`

## Requirements
- R1: After reset `busy` and `done` are low and both lane enables (`bus_le`, `bus_he`) are low.
- R2: A byte, or a word at an even address, takes a single cycle at the even address holding it. A byte enables only the low lane when address bit 0 is 0, and only the high lane when it is 1. An even word enables both lanes.
- R3: With base B = address with bits 1:0 cleared, a word at B+1 runs B (high lane only) then B+2 (low lane only). A word at B+3 runs B+4 (low lane only) then B+2 (high lane only).
- R4: A doubleword at B runs B then B+2. A doubleword at B+2 runs B+4 then B+2. Every cycle in both cases enables both lanes.
- R5: A doubleword at B+1 runs B+4 (low lane), then B (high lane), then B+2 (both lanes). A doubleword at B+3 runs B+4 (both lanes), then B+6 (low lane), then B+2 (high lane). Addresses wrap modulo 2^ADDR_W.
- R6: While a cycle is active and `bus_ready` is low, `bus_addr`, the lane enables, `bus_we` and `bus_wdata` stay unchanged.
- R7: On writes, an enabled lane whose byte address is b carries operand byte (b - address), taken from `req_wdata[8k+7:8k]` with k = b - address. `bus_we` is high in every cycle of a write and low in every cycle of a read.
- R8: After a read, `rdata` byte k holds the byte read from address+k for each k below the operand length. Bytes beyond the operand length are zero.
- R9: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the cycle in which the final ready is sampled. `done` is high for exactly the next cycle, with `busy` low. A request presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| req_addr | input | ADDR_W | Operand byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write operand, byte k at bits 8k+7:8k |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final bus cycle |
| rdata | output | 32 | Read result in operand order |
| bus_addr | output | ADDR_W | Even byte address of the current cycle |
| bus_le | output | 1 | Low lane (bits 7:0) enable |
| bus_he | output | 1 | High lane (bits 15:8) enable |
| bus_we | output | 1 | Current cycle is a write |
| bus_wdata | output | 16 | Write data on the two lanes |
| bus_rdata | input | 16 | Read data from the two lanes |
| bus_ready | input | 1 | Ends the current cycle when high at a clock edge |

## Verification
The bench sweeps every size against every offset within a doubleword. It runs each combination as both a read and a write, at three bases, including bases near the top of the address space where B+4 and B+6 wrap. This targets the out-of-order cases. A design that issued misaligned cycles in ascending order, or dropped the wrap-back cycle, would show the wrong address or lane pattern in a specific step. A lane-steering error would put a neighbouring operand byte on the lane or assemble reads shifted by one byte. The bench inserts wait cycles of varying length and holds a conflicting request high throughout each sequence. A design that advanced without ready, or restarted on a new request, would then change its bus outputs mid-cycle or end with the wrong cycle count.

// File: rtl/bus_split_seq.sv
module bus_split_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_le,
  output logic              bus_he,
  output logic              bus_we,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ready
);

  // step plan: {last, word offset from base in words, low lane, high lane}
  function automatic logic [4:0] plan(input logic [1:0] sz, input logic [1:0] a,
                                      input logic [1:0] st);
    logic [4:0] p;
    p = 5'b10011;
    if (sz == 2'd0) begin
      p = {1'b1, 1'b0, a[1], ~a[0], a[0]};
    end else if (sz == 2'd1) begin
      case (a)
        2'd0: p = {1'b1, 2'd0, 2'b11};
        2'd1: p = (st == 2'd0) ? {1'b0, 2'd0, 2'b01} : {1'b1, 2'd1, 2'b10};
        2'd2: p = {1'b1, 2'd1, 2'b11};
        default: p = (st == 2'd0) ? {1'b0, 2'd2, 2'b10} : {1'b1, 2'd1, 2'b01};
      endcase
    end else begin
      case (a)
        2'd0: p = (st == 2'd0) ? {1'b0, 2'd0, 2'b11} : {1'b1, 2'd1, 2'b11};
        2'd1: case (st)
                2'd0:    p = {1'b0, 2'd2, 2'b10};
                2'd1:    p = {1'b0, 2'd0, 2'b01};
                default: p = {1'b1, 2'd1, 2'b11};
              endcase
        2'd2: p = (st == 2'd0) ? {1'b0, 2'd2, 2'b11} : {1'b1, 2'd1, 2'b11};
        default: case (st)
                2'd0:    p = {1'b0, 2'd2, 2'b11};
                2'd1:    p = {1'b0, 2'd3, 2'b10};
                default: p = {1'b1, 2'd1, 2'b01};
              endcase
      endcase
    end
    return p;
  endfunction

  logic [1:0]        size_q, step;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [31:0]       wdata_q;
  logic [4:0]        cur;
  logic [2:0]        off;
  logic [1:0]        lo_i, hi_i;
  logic              fin;

  assign cur  = plan(size_q, addr_q[1:0], step);
  assign off  = {cur[3:2], 1'b0};
  assign lo_i = off[1:0] - addr_q[1:0];
  assign hi_i = lo_i + 2'd1;
  assign fin  = busy && bus_ready && cur[4];

  assign bus_addr  = {addr_q[ADDR_W-1:2], 2'b00} + ADDR_W'(off);
  assign bus_le    = busy && cur[1];
  assign bus_he    = busy && cur[0];
  assign bus_we    = busy && we_q;
  assign bus_wdata = {wdata_q[{hi_i, 3'b000} +: 8], wdata_q[{lo_i, 3'b000} +: 8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= 2'd0;
      size_q  <= 2'd0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      done <= fin;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          step    <= 2'd0;
          size_q  <= req_size;
          addr_q  <= req_addr;
          we_q    <= req_write;
          wdata_q <= req_wdata;
          rdata   <= '0;
        end
      end else if (bus_ready) begin
        if (cur[1]) rdata[{lo_i, 3'b000} +: 8] <= bus_rdata[7:0];
        if (cur[0]) rdata[{hi_i, 3'b000} +: 8] <= bus_rdata[15:8];
        if (cur[4]) busy <= 1'b0;
        else        step <= step + 2'd1;
      end
    end
  end

  // R6
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_ready |=> $stable(bus_addr) && $stable(bus_le) && $stable(bus_he)
                           && $stable(bus_we) && $stable(bus_wdata));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R2
  lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_le || bus_he));

  // R2
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bus_addr[0]);

endmodule

// File: tb/test_bus_split_seq.sv
module test_bus_split_seq;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          busy, done, bus_le, bus_he, bus_we;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          bus_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_split_seq #(.ADDR_W(AW)) i_bus_split_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_le(bus_le), .bus_he(bus_he), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  function automatic logic [7:0] mem(input logic [AW-1:0] b);
    return b[7:0] * 8'd7 + b[15:8] + 8'd3;
  endfunction

  // expected step: {last, byte offset from base, low lane, high lane}
  function automatic logic [5:0] exp_step(input int sz, input int a, input int st);
    if (sz == 0) return {1'b1, 3'(a & 2), a[0] == 1'b0, a[0] == 1'b1};
    if (sz == 1) begin
      if (a == 0) return {1'b1, 3'd0, 2'b11};
      if (a == 2) return {1'b1, 3'd2, 2'b11};
      if (a == 1) return (st == 0) ? {1'b0, 3'd0, 2'b01} : {1'b1, 3'd2, 2'b10};
      return (st == 0) ? {1'b0, 3'd4, 2'b10} : {1'b1, 3'd2, 2'b01};
    end
    if (a == 0) return (st == 0) ? {1'b0, 3'd0, 2'b11} : {1'b1, 3'd2, 2'b11};
    if (a == 2) return (st == 0) ? {1'b0, 3'd4, 2'b11} : {1'b1, 3'd2, 2'b11};
    if (a == 1) return (st == 0) ? {1'b0, 3'd4, 2'b10} :
                       (st == 1) ? {1'b0, 3'd0, 2'b01} : {1'b1, 3'd2, 2'b11};
    return (st == 0) ? {1'b0, 3'd4, 2'b11} :
           (st == 1) ? {1'b0, 3'd6, 2'b10} : {1'b1, 3'd2, 2'b01};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int sz, input int a, input logic [AW-1:0] base, input bit we);
    logic [AW-1:0] addr;
    logic [31:0]   wd, exp_r;
    logic [5:0]    e;
    logic [AW-1:0] ea, snap_a, b;
    logic [15:0]   snap_d;
    string         tag;
    int            n, st, k;
    addr = base + AW'(a);
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    wd = 32'hA1B2C3D4 ^ {addr, addr} ^ {30'd0, sz[1:0]};
    if (sz == 0 || (sz == 1 && a[0] == 1'b0)) tag = "R2";
    else if (sz == 1) tag = "R3";
    else if (a[0] == 1'b0) tag = "R4";
    else tag = "R5";
    @(negedge clk);
    req_valid = 1'b1; req_size = 2'(sz); req_addr = addr;
    req_write = we; req_wdata = wd;
    @(negedge clk);
    req_size = 2'd2; req_addr = ~addr; req_write = ~we; req_wdata = ~wd;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    st = 0;
    while (busy && st < 4) begin
      e = exp_step(sz, a, st);
      ea = base + AW'(e[4:2]);
      chk({tag, " addr"}, {16'd0, bus_addr}, {16'd0, ea});
      chk({tag, " lanes"}, {30'd0, bus_le, bus_he}, {30'd0, e[1:0]});
      chk("R7 we", {31'd0, bus_we}, {31'd0, we});
      if (we) begin
        for (int l = 0; l < 2; l++) begin
          if (e[1 - l]) begin
            b = ea + AW'(l);
            k = int'(AW'(b - addr));
            chk("R7 lane data", {24'd0, bus_wdata[8*l +: 8]}, {24'd0, wd[8*k +: 8]});
          end
        end
      end
      snap_a = bus_addr; snap_d = bus_wdata;
      repeat ((st + a) % 3) begin
        bus_ready = 1'b0;
        @(negedge clk);
        chk("R6 hold", {bus_addr, bus_wdata}, {snap_a, snap_d});
      end
      bus_ready = 1'b1;
      bus_rdata = {mem(bus_addr + AW'(1)), mem(bus_addr)};
      @(negedge clk);
      bus_ready = 1'b0;
      st++;
    end
    req_valid = 1'b0;
    chk({tag, " cycle count"}, st, (sz == 0 || (sz == 1 && a[0] == 1'b0)) ? 1 :
                                   (sz == 2 && a[0] == 1'b1) ? 3 : 2);
    chk("R9 done", {31'd0, done}, 32'd1);
    if (!we) begin
      exp_r = '0;
      for (int j = 0; j < n; j++) exp_r[8*j +: 8] = mem(addr + AW'(j));
      chk("R8 rdata", rdata, exp_r);
    end
    @(negedge clk);
    chk("R9 done pulse and ignored request", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {28'd0, busy, done, bus_le, bus_he}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {28'd0, busy, done, bus_le, bus_he}, 32'd0);
    foreach (bases_arr[i]) begin
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 4; a++)
          for (int w = 0; w < 2; w++)
            run(sz, a, bases_arr[i], w[0]);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [AW-1:0] bases_arr [3] = '{16'h0010, 16'hFFF8, 16'hFFFC};

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule